// File: doc/BRIEF.md
# Chainable Time-Slot Serial Port for a Stereo Codec

This block is the digital serial port of a stereo audio converter. It moves 16-bit words, most significant bit first, over a time-division-multiplexed bus whose frame holds 32 slots of 16 bit clocks each. During one transaction, or window, the port receives a control word and a left and right playback word, and it sends a status-or-readback word and a left and right capture word. All logic runs on the serial bit clock `clk`. Inputs are sampled on its rising edge, and outputs change on the same edge.

There are two slot layouts. In sequential mode (`slot_mode`=0) the window covers six slots: the three input words come first, then the three output words, so the input and output can share one wire. In concurrent mode (`slot_mode`=1) the window covers three slots, and each output word is sent while the matching input word arrives. When `master`=1, the port divides the bit clock into frames itself and starts each window on its own frame sync. With one sample per frame it starts one window per frame. With two samples per frame it starts a second window at the half-frame point. When `master`=0, the port is a chained follower that starts only on the token `tsi`. Its `tso` token passes the bus on to the next device.

The control word has four fields. Bit 14 is the read request, bit 13 is the write enable, bits 11:8 are the index, and bits 7:0 are the data. These fields reach a 16-entry table of 8-bit index registers. The status slot returns either the external status word or the contents of one index register.

Top module: `tdm_codec_port`

## Requirements
- R1: With `master`=1, `fs_out` is a one-cycle pulse once every 512 clocks. The first pulse comes in the 512th cycle after reset is released. Bit 0 of the first window slot follows in the next cycle.
- R2: With `master`=1 and `frame_rate`=0, a second window starts 256 clocks after each frame-sync window start. With `frame_rate`=1, there is only one window per frame.
- R3: In sequential mode, window slots 0, 1 and 2 are received from `sdi`, MSB first, into `ctrl_word`, `play_left` and `play_right`. Each register updates at the edge that ends the word's last bit. Slots 3, 4 and 5 send the status-or-readback word, `cap_left` and `cap_right`, MSB first.
- R4: In concurrent mode, window slots 0, 1 and 2 receive control, left playback and right playback. During those same slots the port sends status-or-readback, left capture and right capture.
- R5: `tso` is high for exactly one cycle, during the last bit of the window's final slot (window cycle 95 in sequential mode, 47 in concurrent mode).
- R6: `sdo_oe` is high only in output slots. `sdo` is 0 whenever `sdo_oe` is low.
- R7: With `master`=0, `fs_out` stays low and frame timing is ignored. A window starts in the cycle after `tsi` is seen high. A `tsi` seen while a window is running is ignored.
- R8: The status slot sends `status_word` when the last received control word had bit 14 clear. When bit 14 was set, it sends readback {bit14=1, other upper bits 0, index in 11:8, register data in 7:0}. A write, when bit 13 is set, stores bits 7:0 into the addressed index register. All index registers reset to 0.
- R9: Indexes 11, 14 and 15 are invalid. A read request to one of them returns `status_word`. A write to one of them changes nothing.
- R10: In sequential mode, a control word received in slot 0 already decides the readback in slot 3 of the same window. In concurrent mode it decides the readback at slot 0 of the next window.
- R11: After reset, `sdo_oe`, `sdo`, `tso` and `fs_out` are low, and `ctrl_word`, `play_left` and `play_right` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master | input | 1 | 1: generate frame sync and start windows; 0: start on the token only |
| slot_mode | input | 1 | 0: six sequential slots; 1: three concurrent slots |
| frame_rate | input | 1 | 0: two windows per frame; 1: one window per frame |
| tsi | input | 1 | Incoming chain token |
| sdi | input | 1 | Serial data in |
| status_word | input | 16 | Status word offered for the status slot |
| cap_left | input | 16 | Left capture word |
| cap_right | input | 16 | Right capture word |
| fs_out | output | 1 | Frame sync pulse when master |
| tso | output | 1 | Outgoing chain token |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the three-state driver of sdo |
| ctrl_word | output | 16 | Last received control word |
| play_left | output | 16 | Last received left playback word |
| play_right | output | 16 | Last received right playback word |

## Verification
On every cycle, the assertions check these properties: frame sync and the token are each single-cycle pulses, `fs_out` stays silent in follower mode, `sdo` is quiet while undriven, and the output enable drops right after the token. Slot placement, the bit order, the choice between readback and status in each mode, and the rejection of invalid indexes cannot be checked that way. Only the bench's scenarios can show them, with its cycle-level model comparing every output on every clock.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
    // Shared constants and field positions of the control word.
    localparam int CW_W       = 16;
    localparam int RD_BIT     = 14;
    localparam int WR_BIT     = 13;
    localparam int IDX_LSB    = 8;
    localparam int IDX_W      = 4;
    localparam int DAT_W      = 8;
    localparam int NUM_IDX    = 1 << IDX_W;
    localparam int SEQ_SLOTS  = 6;
    localparam int CONC_SLOTS = 3;

    // True for index addresses that are not implemented.
    function automatic logic idx_invalid(input logic [IDX_W-1:0] idx);
        return (idx == 4'd11) || (idx == 4'd14) || (idx == 4'd15);
    endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
// Frame divider for master operation. Counts bit clocks over one frame.
// Raises the frame sync in the last cycle of the frame, and requests a window
// start at the frame edge and, in two-sample mode, at the half-frame point.
// Assumes that frame_rate changes only between windows.
module tdm_frame_timer #(
    parameter int FRAME_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic frame_rate,
    output logic fs_out,
    output logic start_req
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(FRAME_BITS / 2 - 1);

    logic [CNT_W-1:0] fcnt;

    // Free-running position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) fcnt <= '0;
        else        fcnt <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
    end

    // Sync pulse and window requests, used only when master.
    always_comb begin
        fs_out    = master && (fcnt == LAST);
        start_req = master && ((fcnt == LAST) || (!frame_rate && fcnt == MID));
    end
endmodule

// File: rtl/tdm_slot_seq.sv
// Window sequencer. After a start it steps through three or six slots of
// WORD_W bits. It reports which kind of slot is active, raises the token in
// the last bit of the window, and says when the transmit register must load
// which output word. Starts that arrive while a window is running are ignored.
module tdm_slot_seq
    import tdm_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mode_in,
    output logic       busy,
    output logic [2:0] slot,
    output logic       in_slot,
    output logic       out_slot,
    output logic       word_end,
    output logic       tso,
    output logic       load_tx,
    output logic [1:0] load_sel
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic             mode_q;
    logic [BIT_W-1:0] bitc;
    logic [2:0]       nxt;
    logic [2:0]       last_slot;
    logic [2:0]       sel_full;

    // Slot decode, token and transmit load timing.
    always_comb begin
        last_slot = mode_q ? 3'(CONC_SLOTS - 1) : 3'(SEQ_SLOTS - 1);
        nxt       = slot + 3'd1;
        word_end  = busy && (bitc == LAST_BIT);
        tso       = word_end && (slot == last_slot);
        in_slot   = busy && (mode_q || slot < 3'(CONC_SLOTS));
        out_slot  = busy && (mode_q || slot >= 3'(CONC_SLOTS));
        load_tx   = (start && !busy && mode_in)
                  || (word_end && !tso && (mode_q || nxt >= 3'(CONC_SLOTS)));
        sel_full  = !busy ? 3'd0 : (mode_q ? nxt : nxt - 3'(CONC_SLOTS));
        load_sel  = sel_full[1:0];
    end

    // Window state: idle or running, slot and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            mode_q <= 1'b0;
            slot   <= '0;
            bitc   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                mode_q <= mode_in;
                slot   <= '0;
                bitc   <= '0;
            end
        end else if (word_end) begin
            busy <= !tso;
            slot <= tso ? 3'd0 : nxt;
            bitc <= '0;
        end else begin
            bitc <= bitc + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_index_file.sv
// Indirect register table of NUM_IDX entries of DAT_W bits. Writes to invalid
// indexes are dropped. The read port is combinational.
module tdm_index_file
    import tdm_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DAT_W-1:0] wr_dat,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DAT_W-1:0] rd_dat
);
    logic [DAT_W-1:0] mem [NUM_IDX];

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_ent
        // One table entry, written only when addressed and valid.
        always_ff @(posedge clk) begin
            if (!rst_n) mem[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i) && !idx_invalid(IDX_W'(i)))
                mem[i] <= wr_dat;
        end
    end

    // Read mux.
    always_comb rd_dat = mem[rd_idx];
endmodule

// File: rtl/tdm_codec_port.sv
// Top of the serial port. Combines the frame timer, the window sequencer and
// the index table with the receive and transmit shift registers.
// Assumes that mode inputs change only while no window is running, and that
// status and capture words are steady at the start of their slots.
module tdm_codec_port
    import tdm_port_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              slot_mode,
    input  logic              frame_rate,
    input  logic              tsi,
    input  logic              sdi,
    input  logic [WORD_W-1:0] status_word,
    input  logic [WORD_W-1:0] cap_left,
    input  logic [WORD_W-1:0] cap_right,
    output logic              fs_out,
    output logic              tso,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] play_left,
    output logic [WORD_W-1:0] play_right
);
    localparam int FRAME_BITS = FRAME_SLOTS * WORD_W;

    logic              timer_start, start;
    logic              busy, in_slot, out_slot, word_end, load_tx;
    logic [2:0]        slot;
    logic [1:0]        load_sel;
    logic [WORD_W-1:0] rx_sh, rx_word, tx_sh, tx_word, readback;
    logic              rreq_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DAT_W-1:0]  rd_dat;
    logic              cw_commit;

    tdm_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .master(master), .frame_rate(frame_rate),
        .fs_out(fs_out), .start_req(timer_start)
    );

    // A master follows its own timer; a follower follows the token.
    always_comb start = master ? timer_start : tsi;

    tdm_slot_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(slot_mode),
        .busy(busy), .slot(slot), .in_slot(in_slot), .out_slot(out_slot),
        .word_end(word_end), .tso(tso), .load_tx(load_tx), .load_sel(load_sel)
    );

    // Received word as it completes, and the control-word commit strobe.
    always_comb begin
        rx_word   = {rx_sh[WORD_W-2:0], sdi};
        cw_commit = word_end && in_slot && slot == 3'd0;
    end

    tdm_index_file u_idx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cw_commit && rx_word[WR_BIT]),
        .wr_idx(rx_word[IDX_LSB +: IDX_W]), .wr_dat(rx_word[DAT_W-1:0]),
        .rd_idx(idx_q), .rd_dat(rd_dat)
    );

    // Receive shifter, word registers and latched read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            ctrl_word  <= '0;
            play_left  <= '0;
            play_right <= '0;
            rreq_q     <= 1'b0;
            idx_q      <= '0;
        end else if (in_slot) begin
            rx_sh <= rx_word;
            if (word_end) begin
                case (slot)
                    3'd0: begin
                        ctrl_word <= rx_word;
                        rreq_q    <= rx_word[RD_BIT];
                        idx_q     <= rx_word[IDX_LSB +: IDX_W];
                    end
                    3'd1:    play_left  <= rx_word;
                    default: play_right <= rx_word;
                endcase
            end
        end
    end

    // Choice of the next outgoing word.
    always_comb begin
        readback                      = '0;
        readback[RD_BIT]              = 1'b1;
        readback[IDX_LSB +: IDX_W]    = idx_q;
        readback[DAT_W-1:0]           = rd_dat;
        case (load_sel)
            2'd0:    tx_word = (rreq_q && !idx_invalid(idx_q)) ? readback : status_word;
            2'd1:    tx_word = cap_left;
            default: tx_word = cap_right;
        endcase
    end

    // Transmit shifter: load at each output slot start, else shift MSB out.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sh <= '0;
        else if (load_tx)  tx_sh <= tx_word;
        else if (out_slot) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end

    // Pin drive.
    always_comb begin
        sdo_oe = out_slot;
        sdo    = out_slot && tx_sh[WORD_W-1];
    end
endmodule

// File: rtl/tdm_codec_port_chk.sv
// Protocol checker for tdm_codec_port, attached by bind.
module tdm_codec_port_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic fs_out,
    input logic tso,
    input logic sdo,
    input logic sdo_oe
);
    p_fs_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |=> !fs_out);
    p_follower_no_fs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> !fs_out);
    p_tso_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tso |=> !tso);
    p_oe_drops_after_tso_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tso |=> !sdo_oe);
    p_tso_in_out_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tso |-> sdo_oe);
    p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
endmodule

bind tdm_codec_port tdm_codec_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .fs_out(fs_out),
    .tso(tso), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/tdm_codec_port_tb.sv
module tdm_codec_port_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0, master = 1'b1, tssel = 1'b0, frs = 1'b1, tsi = 1'b0, sdi = 1'b0;
    logic [15:0] status_w = 16'h0, cap_l = 16'h0, cap_r = 16'h0;
    logic        fs_out, tso, sdo, sdo_oe;
    logic [15:0] ctrl_word, play_left, play_right;

    tdm_codec_port u_dut (
        .clk(clk), .rst_n(rst_n), .master(master), .slot_mode(tssel),
        .frame_rate(frs), .tsi(tsi), .sdi(sdi), .status_word(status_w),
        .cap_left(cap_l), .cap_right(cap_r), .fs_out(fs_out), .tso(tso),
        .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_word(ctrl_word),
        .play_left(play_left), .play_right(play_right)
    );

    // Behavioural reference state.
    int          m_fc, m_pos;
    logic        m_mode, m_rreq;
    logic [3:0]  m_idx;
    logic [15:0] m_rx, m_ctrl, m_pl, m_pr, m_out;
    logic [7:0]  m_file [16];
    logic [15:0] in_w [3];
    int          n_cmp = 0, n_bad = 0;
    string       tag = "R11";

    function automatic logic bad_idx(input logic [3:0] i);
        return i == 4'd11 || i == 4'd14 || i == 4'd15;
    endfunction

    function automatic logic [15:0] pick(input int k);
        if (k == 0)
            return (m_rreq && !bad_idx(m_idx)) ? {4'b0100, m_idx, m_file[m_idx]} : status_w;
        else if (k == 1) return cap_l;
        else             return cap_r;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin : model
        int   len;
        logic trig;
        if (!rst_n) begin
            m_fc = 0; m_pos = -1; m_mode = 0; m_rreq = 0; m_idx = 0;
            m_rx = 0; m_ctrl = 0; m_pl = 0; m_pr = 0; m_out = 0;
            for (int i = 0; i < 16; i++) m_file[i] = 8'h00;
        end else begin
            len  = m_mode ? 48 : 96;
            trig = master ? (m_fc == 511 || (!frs && m_fc == 255)) : tsi;
            if (m_pos >= 0) begin
                if (m_mode || m_pos < 48) begin
                    m_rx = {m_rx[14:0], sdi};
                    if (m_pos % 16 == 15) begin
                        if (m_pos / 16 == 0) begin
                            m_ctrl = m_rx; m_rreq = m_rx[14]; m_idx = m_rx[11:8];
                            if (m_rx[13] && !bad_idx(m_rx[11:8])) m_file[m_rx[11:8]] = m_rx[7:0];
                        end else if (m_pos / 16 == 1) m_pl = m_rx;
                        else m_pr = m_rx;
                    end
                end
                if (m_pos == len - 1) m_pos = -1;
                else m_pos++;
            end else if (trig) begin
                m_pos = 0; m_mode = tssel;
            end
            m_fc = (m_fc + 1) % 512;
            if (m_pos >= 0 && m_pos % 16 == 0 && (m_mode || m_pos >= 48))
                m_out = pick(m_mode ? m_pos / 16 : m_pos / 16 - 3);
        end
    end

    task automatic check(input string t, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h at %0t", t, what, got, exp, $time);
        end
    endtask

    // One cycle: compare at the falling edge, then drive serial input.
    task automatic tick();
        logic exp_oe, exp_sdo, exp_tso;
        @(negedge clk);
        exp_oe  = m_pos >= 0 && (m_mode || m_pos >= 48);
        exp_sdo = exp_oe ? m_out[15 - m_pos % 16] : 1'b0;
        exp_tso = m_pos == (m_mode ? 47 : 95);
        check("R6", "sdo_oe", 16'(sdo_oe), 16'(exp_oe));
        check(tag,  "sdo", 16'(sdo), 16'(exp_sdo));
        check("R5", "tso", 16'(tso), 16'(exp_tso));
        check(master ? "R1" : "R7", "fs_out", 16'(fs_out), 16'(master && m_fc == 511));
        check("R3", "ctrl_word", ctrl_word, m_ctrl);
        check("R3", "play_left", play_left, m_pl);
        check("R3", "play_right", play_right, m_pr);
        if (m_pos >= 0 && (m_mode || m_pos < 48)) sdi = in_w[m_pos / 16][15 - m_pos % 16];
        else sdi = 1'b0;
    endtask

    // Set up one window's words while idle, then run it to completion.
    task automatic window(input string t, input logic mode, input logic [15:0] cw,
                          input logic [15:0] pl, input logic [15:0] pr, input logic [15:0] st);
        while (m_pos >= 0) tick();
        tag = t; tssel = mode;
        in_w[0] = cw; in_w[1] = pl; in_w[2] = pr;
        status_w = st; cap_l = pl ^ 16'hF0F0; cap_r = ~pr;
        while (m_pos < 0) tick();
        while (m_pos >= 0) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state visible at the ports.
        check("R11", "idle outputs", {12'h0, sdo_oe, sdo, tso, fs_out}, 16'h0);
        check("R11", "ctrl_word", ctrl_word, 16'h0);
        check("R11", "play words", play_left | play_right, 16'h0);
        // R3: sequential layout, status word since no read request.
        window("R3", 1'b0, 16'h0000, 16'h1234, 16'hABCD, 16'h5A5A);
        // R10: write+read index 3 in slot 0 shows in slot 3 of same window.
        window("R10", 1'b0, 16'h63A5, 16'h8001, 16'h7FFE, 16'h1111);
        // R8: read request with index 0 returns reset value zero in readback.
        window("R8", 1'b0, 16'h4000, 16'hC3C3, 16'h3C3C, 16'h2222);
        window("R8", 1'b0, 16'h653C, 16'h0F0F, 16'hF0F0, 16'h3333);
        // R2/R4: two windows per frame, concurrent slots.
        frs = 1'b0;
        window("R4", 1'b1, 16'h4300, 16'hAAAA, 16'h5555, 16'h4444);
        window("R2", 1'b1, 16'h0000, 16'h0001, 16'h8000, 16'h6666);
        // R10: concurrent mode, read request acts one window later.
        window("R10", 1'b1, 16'h4500, 16'h1357, 16'h2468, 16'h7777);
        window("R10", 1'b1, 16'h0000, 16'h9ABC, 16'hDEF0, 16'h8888);
        // R9: invalid indexes: write ignored, read gives status.
        window("R9", 1'b1, 16'h6BFF, 16'h1111, 16'h2222, 16'h9999);
        window("R9", 1'b1, 16'h4E00, 16'h3333, 16'h4444, 16'hAAAB);
        window("R9", 1'b1, 16'h4F00, 16'h5555, 16'h6666, 16'hBBBC);
        window("R9", 1'b0, 16'h4B00, 16'h7777, 16'h8888, 16'hCCCD);
        frs = 1'b1;
        window("R2", 1'b0, 16'h4500, 16'h1010, 16'h2020, 16'hDDDE);
        // R7: follower mode, token starts the window.
        while (m_pos >= 0) tick();
        master = 1'b0; tag = "R7";
        repeat (40) tick();
        tssel = 1'b0; in_w[0] = 16'h4300; in_w[1] = 16'h0C0C; in_w[2] = 16'h3030;
        tick(); tsi = 1'b1; tick(); tsi = 1'b0;
        repeat (20) tick();
        tsi = 1'b1; tick(); tsi = 1'b0;   // R7: token during a window is ignored
        while (m_pos >= 0) tick();
        tssel = 1'b1;
        tick(); tsi = 1'b1; tick(); tsi = 1'b0;
        while (m_pos >= 0) tick();
        repeat (600) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R5 watchdog got hung exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule